// File: doc/BRIEF.md
# TDM Frame Receiver

This block turns one serial receive line of a time-division-multiplexed link into parallel channel bytes. A bit clock and an active-high frame pulse arrive with the data, and the transmit direction uses the same clock and pulse. The receiver looks for the frame pulse on the rising clock edge. It samples the data line on the falling clock edge. A frame is 256 bit periods long. The bit period in which the frame pulse is seen carries the first bit of the frame, so there is no offset between pulse and data.

Only the first 32 bit periods of a frame hold payload. They are four 8-bit channels, and each channel's most significant bit comes first. When the last bit of a channel has been taken in, the block presents the byte and its channel number together with a one-cycle valid pulse. If a frame pulse arrives at any bit position other than the expected frame start, the block flags it with a one-cycle error pulse and restarts its bit count from that pulse.

Top module: `tdm_rx`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `ch_valid_o` and `sync_err_o` are 0.
- R2: Between reset and the first frame pulse, no valid pulse is produced, whatever the data line carries.
- R3: Each output byte holds the eight bits of one channel in arrival order. The first bit to arrive sits in bit 7 and the last in bit 0.
- R4: `ch_idx_o` gives the slot number. Slot 0 holds frame bits 0 to 7, slot 1 bits 8 to 15, slot 2 bits 16 to 23 and slot 3 bits 24 to 31. Within one frame the bytes come out in slot order 0, 1, 2, 3.
- R5: The data line is sampled on the falling clock edge. A value that is present only around the falling edge is the one captured.
- R6: The frame pulse is sampled on the rising clock edge. The data bit sampled on the falling edge of that same bit period is frame bit 0.
- R7: Frame bits 32 to 255 produce no output and do not change any channel byte.
- R8: Each valid pulse lasts exactly one clock cycle. A frame with no realignment gives exactly four pulses, and each pulse is raised at the rising edge after the falling edge that captured the channel's last bit.
- R9: A frame pulse seen while aligned at a position other than frame bit 0 raises `sync_err_o` for one cycle. That pulse is frame bit 0 of a new frame, and counting starts again from it.
- R10: The first frame pulse after reset does not raise `sync_err_o`. A frame pulse that arrives exactly 256 bit periods after the previous frame start does not raise it either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, shared with the transmit direction |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Active-high frame pulse, sampled on the rising edge |
| rx_data_i | input | 1 | Serial receive data, sampled on the falling edge |
| ch_data_o | output | 8 | Completed channel byte, first-arrived bit in bit 7 |
| ch_idx_o | output | 2 | Slot number of the byte on `ch_data_o` |
| ch_valid_o | output | 1 | One-cycle strobe marking a new byte |
| sync_err_o | output | 1 | One-cycle pulse on a misplaced frame pulse |

## Verification
The assertions assume that a frame pulse lasts a single bit period. They also assume that frame pulses, when they are not misplaced on purpose, are spaced a full 256 bits apart, so two valid strobes are never adjacent. The stimulus keeps to this. It raises the pulse only for the rising edge that is meant to see it. It changes the data line just after each rising edge and again, to the inverted value, just after each falling edge, so only falling-edge sampling yields the intended bytes. One frame is deliberately cut short to place a frame pulse at a wrong position, and the expected error and realignment are predicted from the bench's own frame model.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    localparam int CH_BITS    = 8;
    localparam int NUM_CH     = 4;
    localparam int FRAME_BITS = 256;

    localparam int CH_IDX_W    = $clog2(NUM_CH);
    localparam int POS_W       = $clog2(FRAME_BITS);
    localparam int ACTIVE_BITS = CH_BITS * NUM_CH;

    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        logic [CH_IDX_W-1:0] chan;
        logic [CH_BITS-1:0]  data;
    } rx_word_t;

    localparam pos_t LAST_POS = pos_t'(FRAME_BITS - 1);

    function automatic logic in_payload(input pos_t p);
        return int'(p) < ACTIVE_BITS;
    endfunction

    function automatic logic closes_slot(input pos_t p);
        return (int'(p) % CH_BITS) == (CH_BITS - 1);
    endfunction

    function automatic logic [CH_IDX_W-1:0] slot_of(input pos_t p);
        int s;
        s = int'(p) / CH_BITS;
        return s[CH_IDX_W-1:0];
    endfunction

endpackage

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
    import tdm_rx_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic sync_i,
    output pos_t pos_o,
    output logic locked_o,
    output logic sync_err_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos_o      <= '0;
            locked_o   <= 1'b0;
            sync_err_o <= 1'b0;
        end else begin
            sync_err_o <= sync_i && locked_o && (pos_o != LAST_POS);
            if (sync_i) begin
                pos_o    <= '0;
                locked_o <= 1'b1;
            end else if (pos_o == LAST_POS) begin
                pos_o <= '0;
            end else begin
                pos_o <= pos_o + pos_t'(1);
            end
        end
    end

    // R9: an error always coincides with a counter restarted at frame bit 0
    p_err_realigns_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_err_o |-> (pos_o == '0));

    // R2: once aligned, alignment is never dropped without reset
    p_lock_sticky_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        locked_o |=> locked_o);

endmodule

// File: rtl/tdm_rx_sampler.sv
module tdm_rx_sampler (
    input  logic clk_i,
    input  logic rst_i,
    input  logic rx_i,
    output logic bit_o
);

    // falling-edge capture of the serial line (R5)
    always_ff @(negedge clk_i) begin
        if (rst_i) bit_o <= 1'b0;
        else       bit_o <= rx_i;
    end

endmodule

// File: rtl/tdm_rx_assembler.sv
module tdm_rx_assembler
    import tdm_rx_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  pos_t     pos_i,
    input  logic     locked_i,
    input  logic     bit_i,
    output rx_word_t word_o,
    output logic     valid_o
);

    logic [CH_BITS-2:0] shreg;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shreg   <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (locked_i && in_payload(pos_i)) begin
                shreg <= {shreg[CH_BITS-3:0], bit_i};
                if (closes_slot(pos_i)) begin
                    valid_o     <= 1'b1;
                    word_o.data <= {shreg, bit_i};
                    word_o.chan <= slot_of(pos_i);
                end
            end
        end
    end

    // R8: a strobe never stretches past one cycle
    p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);

endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
    import tdm_rx_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                sync_i,
    input  logic                rx_data_i,
    output logic [CH_BITS-1:0]  ch_data_o,
    output logic [CH_IDX_W-1:0] ch_idx_o,
    output logic                ch_valid_o,
    output logic                sync_err_o
);

    pos_t     pos;
    logic     locked;
    logic     rx_bit;
    rx_word_t word;

    tdm_rx_framer u_framer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sync_i     (sync_i),
        .pos_o      (pos),
        .locked_o   (locked),
        .sync_err_o (sync_err_o)
    );

    tdm_rx_sampler u_sampler (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .rx_i  (rx_data_i),
        .bit_o (rx_bit)
    );

    tdm_rx_assembler u_asm (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .pos_i    (pos),
        .locked_i (locked),
        .bit_i    (rx_bit),
        .word_o   (word),
        .valid_o  (ch_valid_o)
    );

    assign ch_data_o = word.data;
    assign ch_idx_o  = word.chan;

    // R2: no byte is ever presented while unaligned
    p_no_data_unlocked_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        ch_valid_o |-> locked);

    // R4: the reported slot matches the position counter one bit past that slot
    p_slot_matches_pos_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        ch_valid_o |-> ((pos == '0) ||
                        (int'(pos) == (int'(ch_idx_o) + 1) * CH_BITS)));

endmodule

// File: tb/sim_tdm_rx.sv
module sim_tdm_rx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync = 1'b0;
    logic       rx_data = 1'b0;
    logic [7:0] ch_data;
    logic [1:0] ch_idx;
    logic       ch_valid;
    logic       sync_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [9:0] exp_q[$];

    logic       m_locked = 1'b0;
    int         m_pos = 0;
    logic [7:0] m_sh = '0;
    logic       prev_v = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_rx u0 (
        .clk_i      (clk),
        .rst_i      (rst),
        .sync_i     (sync),
        .rx_data_i  (rx_data),
        .ch_data_o  (ch_data),
        .ch_idx_o   (ch_idx),
        .ch_valid_o (ch_valid),
        .sync_err_o (sync_err)
    );

    // one bit period: pulse visible only to the rising edge, data only around the falling edge
    task automatic drive_bit(input logic s, input logic d);
        logic exp_err;
        @(negedge clk); #1;
        rx_data = ~rx_data;
        sync = s;
        @(posedge clk); #1;
        rx_data = d;
        sync = 1'b0;
        exp_err = s && m_locked && (m_pos != 255);
        n_chk++;
        if (sync_err !== exp_err) begin
            n_bad++;
            $display("FAIL R9/R10 sync_err actual=%b expected=%b (pos %0d)", sync_err, exp_err, m_pos);
        end
        if (s) begin
            m_pos = 0;
            m_locked = 1'b1;
        end else begin
            m_pos = (m_pos + 1) % 256;
        end
        if (m_locked && m_pos < 32) begin
            m_sh = {m_sh[6:0], d};
            if (m_pos % 8 == 7) exp_q.push_back({2'(m_pos / 8), m_sh});
        end
    endtask

    // R3 R4 R6 R7: bits 0..31 carry chans MSB first, later bits are filler
    task automatic send_frame(input logic [31:0] chans, input int len, input logic with_sync);
        for (int i = 0; i < len; i++)
            drive_bit(with_sync && i == 0, i < 32 ? chans[31-i] : logic'(((i * 5 + 3) % 7) < 3));
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (ch_valid) begin
                n_chk++;
                if (prev_v) begin
                    n_bad++;
                    $display("FAIL R8 valid high two cycles actual=1 expected=0");
                end
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R2/R7 unexpected byte actual=%h idx=%0d expected=none", ch_data, ch_idx);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    if ({ch_idx, ch_data} !== e) begin
                        n_bad++;
                        $display("FAIL R3/R4/R5 byte actual=%0d:%h expected=%0d:%h",
                                 ch_idx, ch_data, e[9:8], e[7:0]);
                    end
                end
            end
            prev_v = ch_valid;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: outputs quiet in reset
        n_chk++;
        if (ch_valid !== 1'b0 || sync_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 in reset actual=%b%b expected=00", ch_valid, sync_err);
        end
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (ch_valid !== 1'b0 || sync_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 after release actual=%b%b expected=00", ch_valid, sync_err);
        end
        m_pos = 0;
        // R2: traffic before any frame pulse yields nothing
        send_frame(32'hDEADBEEF, 40, 1'b0);
        // R6 R10: first pulse, no error; R5 via inverted data around the rising edge
        send_frame(32'hA53CFF01, 256, 1'b1);
        // R10: correctly spaced pulse
        send_frame(32'h00807EC3, 256, 1'b1);
        // short frame so the following pulse is misplaced
        send_frame(32'h12345678, 100, 1'b1);
        // R9: misplaced pulse realigns
        send_frame(32'hF00F55AA, 256, 1'b1);
        // R10 after realignment
        send_frame(32'h5AC3817E, 256, 1'b1);
        // trailing bits without a pulse: wrap continues the frame count
        send_frame(32'h9F000000, 12, 1'b0);
        repeat (4) @(negedge clk);
        // R8: all predicted bytes arrived
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R8 missing bytes actual=%0d left expected=0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule